// File: doc/BRIEF.md
# Handshaked Byte SPI Master

This block is a byte-wide SPI master that software drives through two 8-bit registers: a data register and a control register. The control register holds a start request, a direction bit and two chip-select enables. It also carries two read-only status flags: one says the transfer has been set up, and one says it has finished. Software writes a byte into the data register. It then sets the start flag, together with the direction and whichever chip select it wants. The block copies the data register into its shift register and clears its bit counter. It then runs eight SPI mode 0 clocks, most significant bit first.

In a write access, the byte shifts out on MOSI, and the data register keeps its value. In a read access, MOSI stays low, and the eight bits sampled from MISO take the place of the data register contents when the last bit finishes. Software polls the done flag, reads the result, and clears the start flag. Clearing the start flag resets both status flags and gets the block ready for the next byte. Clearing it in the middle of a transfer stops that transfer.

The SCLK half-period is `HALF_DIV` system clock cycles, so one byte takes `16*HALF_DIV` cycles. The two chip-select outputs are active-high and follow their control bits directly.

Top module: `spi_byte_ctl`

## Requirements
- R1: After reset, both registers read 0x00, and SCLK, MOSI and both chip-select outputs are low.
- R2: Control register layout: bit 0 is the codec select, bit 1 is the touch select, bit 2 is the direction (0 = write, 1 = read), bit 3 is done (read-only), bit 4 is start (read/write), bit 5 is loaded (read-only), and bits 7:6 read 0. Writes to bits 7:6, 5 and 3 have no effect. `cs_codec` and `cs_touch` follow bits 0 and 1.
- R3: A control write that sets start to 1 while start reads 0 begins a transfer. From the next cycle, loaded reads 1 and done reads 0.
- R4: In a write access, the block shifts out the byte that the data register held at start. The byte goes out MSB first on MOSI in SPI mode 0: SCLK idles low, and MOSI is stable at every rising SCLK edge. Each SCLK level lasts HALF_DIV clock cycles.
- R5: Done reads 1 exactly 16*HALF_DIV clock edges after the start write edge, and not before. SCLK is low whenever done is 1 or loaded is 0.
- R6: In a read access, MOSI stays low. The block samples MISO at each rising SCLK edge, MSB first, and the data register holds the sampled byte once done reads 1.
- R7: A write access leaves the data register unchanged.
- R8: A data register write while a transfer is in progress (loaded 1, done 0) is ignored. Writes are accepted when no transfer is in progress.
- R9: A control write with start 0 clears start, loaded and done on the next cycle. If a transfer is running, it stops and SCLK returns low.
- R10: A control write with start 1 while start already reads 1 begins no new transfer: done and loaded keep their values and SCLK stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 data, 1 control |
| wr_data | input | 8 | Write value |
| data_rd | output | 8 | Data register contents |
| ctrl_rd | output | 8 | Control register contents including status |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_touch | output | 1 | Touch device select, active high |
| cs_codec | output | 1 | Codec select, active high |

## Verification
Register writes take effect on the clock edge that samples the strobe, so the bench reads `ctrl_rd` and `data_rd` at the falling clock edge that follows the write. Done is due exactly `16*HALF_DIV` edges after the start edge. The bench counts falling clock edges from the write and checks that done is still low one edge early and high on the edge where it is due. MOSI is read at each rising SCLK edge, where it has been stable for a full half period. MISO is changed at each falling SCLK edge, which leaves the design's sampling point mid-way through the SCLK cycle. An exhaustive sweep runs all 256 byte values in both directions, with a MISO pattern derived from each value.

// File: rtl/spi_byte_ctl.sv
module spi_byte_ctl #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] data_rd,
  output logic [7:0] ctrl_rd,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       cs_touch,
  output logic       cs_codec
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [7:0]    dreg, shreg, rxreg;
  logic          start, loaded, done, dir, sel_t, sel_c, ph;
  logic [2:0]    bitc;
  logic [DW-1:0] divc;
  logic          busy, ctrl_wr, data_wr, tick;

  assign busy    = loaded & ~done;
  assign ctrl_wr = wr_en & wr_sel;
  assign data_wr = wr_en & ~wr_sel;
  assign tick    = busy & (divc == DIV_LAST);

  assign data_rd  = dreg;
  assign ctrl_rd  = {2'b00, loaded, start, done, dir, sel_t, sel_c};
  assign sclk     = ph;
  assign mosi     = busy & ~dir & shreg[7];
  assign cs_touch = sel_t;
  assign cs_codec = sel_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg <= '0; shreg <= '0; rxreg <= '0;
      start <= 1'b0; loaded <= 1'b0; done <= 1'b0;
      dir <= 1'b0; sel_t <= 1'b0; sel_c <= 1'b0;
      ph <= 1'b0; bitc <= '0; divc <= '0;
    end else if (ctrl_wr) begin
      dir   <= wr_data[2];
      sel_t <= wr_data[1];
      sel_c <= wr_data[0];
      start <= wr_data[4];
      if (!wr_data[4]) begin
        loaded <= 1'b0;
        done   <= 1'b0;
        ph     <= 1'b0;
        divc   <= '0;
      end else if (!start) begin
        loaded <= 1'b1;
        done   <= 1'b0;
        shreg  <= dreg;
        rxreg  <= '0;
        bitc   <= '0;
        divc   <= '0;
        ph     <= 1'b0;
      end
    end else begin
      if (data_wr && !busy)
        dreg <= wr_data;
      if (busy) begin
        divc <= tick ? '0 : divc + 1'b1;
        if (tick) begin
          ph <= ~ph;
          if (!ph) begin
            rxreg <= {rxreg[6:0], miso};
          end else begin
            shreg <= {shreg[6:0], 1'b0};
            bitc  <= bitc + 1'b1;
            if (bitc == 3'd7) begin
              done <= 1'b1;
              if (dir) dreg <= rxreg;
            end
          end
        end
      end
    end
  end
endmodule

module spi_byte_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] data_rd,
  input logic [7:0] ctrl_rd,
  input logic       sclk,
  input logic       mosi
);
  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd[5] || ctrl_rd[3]) |-> !sclk);
  // R6
  rd_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[2] |-> !mosi);
  // R3
  load_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rd[5]) |-> !ctrl_rd[3]);
  // R9
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel && !wr_data[4]) |=> (ctrl_rd[5:3] == 3'b000));
  // R8
  busy_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && ctrl_rd[5] && !ctrl_rd[3] && !ctrl_rd[2]) |=> $stable(data_rd));
  // R2
  ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[7:6] == 2'b00);
endmodule

bind spi_byte_ctl spi_byte_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .data_rd(data_rd), .ctrl_rd(ctrl_rd), .sclk(sclk), .mosi(mosi)
);

// File: tb/tb_spi_byte_ctl.sv
`timescale 1ns/1ps
module tb_spi_byte_ctl;
  localparam int H = 2;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, miso = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] data_rd, ctrl_rd;
  logic sclk, mosi, cs_touch, cs_codec;
  int checks = 0, errors = 0;

  spi_byte_ctl #(.HALF_DIV(H)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .data_rd(data_rd), .ctrl_rd(ctrl_rd), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_touch(cs_touch), .cs_codec(cs_codec)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] v, input logic rd, input logic [7:0] m);
    logic [7:0] cap;
    logic saw_sclk;
    cap = '0;
    saw_sclk = 1'b0;
    wr(1'b0, v);
    miso = m[7];
    wr(1'b1, {3'b000, 1'b1, 1'b0, rd, 2'b10});
    chk("R3 loaded/done after start", {6'd0, ctrl_rd[5], ctrl_rd[3]}, 8'h02);
    fork
      begin
        for (int i = 0; i < 8; i++) begin
          @(posedge sclk);
          cap[7-i] = mosi;
          if (i < 7) begin
            @(negedge sclk);
            miso = m[6-i];
          end
        end
      end
      begin
        repeat (16*H - 1) @(negedge clk);
        chk("R5 done not early", {7'd0, ctrl_rd[3]}, 8'h00);
        @(negedge clk);
        chk("R5 done on time", {7'd0, ctrl_rd[3]}, 8'h01);
      end
    join
    if (rd) begin
      chk("R6 mosi low in read", cap, 8'h00);
      chk("R6 received byte", data_rd, m);
    end else begin
      chk("R4 shifted byte", cap, v);
      chk("R7 data kept", data_rd, v);
    end
    wr(1'b1, 8'h02);
    chk("R9 flags cleared", {5'd0, ctrl_rd[5:3]}, 8'h00);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", c_dummy());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int c_dummy();
    return 150000;
  endfunction

  initial begin
    #1;
    chk("R1 data reset", data_rd, 8'h00);
    chk("R1 ctrl reset", ctrl_rd, 8'h00);
    chk("R1 pins reset", {4'd0, sclk, mosi, cs_touch, cs_codec}, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 layout, read-only bits, chip-select pins
    wr(1'b1, 8'hEF);
    chk("R2 ctrl bits", ctrl_rd, 8'h07);
    chk("R2 cs pins", {6'd0, cs_touch, cs_codec}, 8'h03);
    wr(1'b1, 8'h02);
    chk("R2 cs touch only", {6'd0, cs_touch, cs_codec}, 8'h02);
    wr(1'b1, 8'h01);
    chk("R2 cs codec only", {6'd0, cs_touch, cs_codec}, 8'h01);

    // R8 idle data write accepted
    wr(1'b0, 8'h3C);
    chk("R8 idle write", data_rd, 8'h3C);

    // R4 R5 R6 R7 exhaustive sweep
    for (int v = 0; v < 256; v++) begin
      xfer(8'(v), 1'b0, 8'(v) ^ 8'hA5);
      xfer(8'(v), 1'b1, 8'(v) ^ 8'hA5);
    end

    // R8 busy write ignored
    wr(1'b0, 8'h96);
    wr(1'b1, 8'h12);
    repeat (5) @(negedge clk);
    wr(1'b0, 8'h5A);
    chk("R8 busy write ignored", data_rd, 8'h96);
    repeat (16*H) @(negedge clk);
    chk("R8 done reached", {7'd0, ctrl_rd[3]}, 8'h01);
    chk("R8 data after done", data_rd, 8'h96);

    // R10 start while start already set
    wr(1'b1, 8'h12);
    chk("R10 flags kept", {5'd0, ctrl_rd[5:3]}, 8'h07);
    repeat (2*H + 1) @(negedge clk);
    chk("R10 no new clocking", {7'd0, sclk}, 8'h00);
    chk("R10 done kept", {7'd0, ctrl_rd[3]}, 8'h01);

    // R9 abort mid-transfer
    wr(1'b1, 8'h02);
    wr(1'b1, 8'h12);
    repeat (3*H) @(negedge clk);
    wr(1'b1, 8'h02);
    chk("R9 abort flags", {5'd0, ctrl_rd[5:3]}, 8'h00);
    repeat (2*H) @(negedge clk);
    chk("R9 abort sclk low", {7'd0, sclk}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule